// File: doc/BRIEF.md
# SPD Image Integrity Checker

The block validates a memory module's presence-detect image while the bus master reads it. The bytes arrive as beats, each carrying an address and a data byte, with ascending addresses that start at zero. Idle cycles may fall between beats. The memory-type byte at address 2 selects the integrity method.

Older module generations (SDR, DDR, DDR2) use an 8-bit additive sum held at address 63. DDR3 images use a CRC-16 held at addresses 126 (low byte) and 127 (high byte). Bit 7 of byte 0 selects how many bytes the CRC covers. The running sum and the running CRC are both accumulated from byte 0, so no bytes need to be replayed once the method is known.

The block raises a one-cycle done pulse when the verdict is ready. Alongside it, the block presents a pass flag, the class of memory it found and an error code. All three hold until the next image starts. Fetching the bytes from the module and decoding timing fields are handled elsewhere.

Top module: `spd_guard`

## Requirements
- R1: After reset, done_o, pass_o, mem_type_o and err_code_o are all 0.
- R2: The byte at address 2 sets mem_type_o as follows: 4 gives 1 (SDR), 7 gives 2 (DDR), 8 gives 3 (DDR2), 11 gives 4 (DDR3).
- R3: For SDR, DDR and DDR2 images, the check passes (pass_o=1, err_code_o=0) when byte 63 equals the modulo-256 sum of bytes 0 to 62, with no negation. The verdict appears in the cycle after the byte-63 beat.
- R4: When the additive sum does not match, the verdict is pass_o=0 and err_code_o=1 (mismatch).
- R5: For DDR3 images, the CRC uses polynomial 0x1021 with initial value 0, bits taken most significant first. It is compared with {byte 127, byte 126}. The verdict appears in the cycle after the byte-127 beat: err_code_o is 0 on a match and 1 on a mismatch.
- R6: For DDR3 images, the CRC covers bytes 0 to 116 when bit 7 of byte 0 is 1, and bytes 0 to 125 when it is 0. Bytes outside the covered range have no effect on the verdict.
- R7: Any other type code ends the check in the cycle after the byte-2 beat, with mem_type_o=0, pass_o=0 and err_code_o=2 (unsupported).
- R8: During a check, a beat whose address is not exactly one above the previous address ends the check in the next cycle with pass_o=0 and err_code_o=3 (sequence). This covers both a gap and a repeated or lower address.
- R9: done_o is high for exactly one cycle per image. pass_o, mem_type_o and err_code_o hold their values until a beat at address 0 starts the next image.
- R10: While no check is running, beats with a nonzero address are ignored: no done pulse, and the result outputs are unchanged.
- R11: Idle cycles between beats (beat_valid_i low) do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | A byte beat is present this cycle |
| beat_addr_i | input | ADDR_W (8) | Byte address of the beat |
| beat_data_i | input | 8 | Byte value of the beat |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Image is intact |
| mem_type_o | output | 3 | Memory class: 0 unknown, 1 SDR, 2 DDR, 3 DDR2, 4 DDR3 |
| err_code_o | output | 2 | 0 none, 1 mismatch, 2 unsupported, 3 sequence |

## Verification
The assertions check the properties that hold on every cycle:
- done never lasts two cycles;
- a pass never carries an error code or an unknown type;
- an unsupported verdict follows only a beat at the type address;
- stray beats while idle never produce a verdict;
- the address tracker restarts at 1 on every new image.

Only the bench scenarios can show whether the sum and CRC values themselves are right, and whether the coverage bit really excludes bytes 117 to 125. They also show that a gap or a backward step is caught at the exact beat, and that idle cycles leave the result unchanged. The bench does this by comparing against reference sums and CRCs computed over random images.

// File: rtl/spd_guard_pkg.sv
package spd_guard_pkg;

  localparam int BYTE_W        = 8;
  localparam int CRC_W         = 16;
  localparam int TYPE_POS      = 2;
  localparam int SUM_LAST_POS  = 62;
  localparam int SUM_POS       = 63;
  localparam int CRC_SHORT_POS = 116;
  localparam int CRC_LONG_POS  = 125;
  localparam int CRC_LO_POS    = 126;
  localparam int CRC_HI_POS    = 127;

  typedef enum logic [2:0] {
    MT_NONE = 3'd0,
    MT_SDR  = 3'd1,
    MT_DDR  = 3'd2,
    MT_DDR2 = 3'd3,
    MT_DDR3 = 3'd4
  } mem_type_e;

  typedef enum logic [1:0] {
    E_NONE     = 2'd0,
    E_MISMATCH = 2'd1,
    E_UNSUP    = 2'd2,
    E_SEQ      = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    M_PEND = 2'd0,
    M_SUM  = 2'd1,
    M_CRC  = 2'd2
  } method_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } state_e;

  function automatic mem_type_e classify(input logic [BYTE_W-1:0] code);
    case (code)
      8'd4:    return MT_SDR;
      8'd7:    return MT_DDR;
      8'd8:    return MT_DDR2;
      8'd11:   return MT_DDR3;
      default: return MT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spd_seq_track.sv
module spd_seq_track #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_order_o
);
  logic [ADDR_W-1:0] exp_q;

  assign in_order_o = (addr_i == exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    exp_q <= '0;
    else if (start_i)               exp_q <= ADDR_W'(1);
    else if (step_i && in_order_o)  exp_q <= exp_q + ADDR_W'(1);
  end

  // R8: a new image always expects address 1 next
  a_r8_restart_at_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> exp_q == ADDR_W'(1));

endmodule

// File: rtl/spd_sum_acc.sv
module spd_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_o <= '0;
    else if (load_i)  sum_o <= byte_i;
    else if (add_i)   sum_o <= sum_o + byte_i;
  end
endmodule

// File: rtl/spd_crc_acc.sv
module spd_crc_acc #(
  parameter int          W      = 8,
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             add_i,
  input  logic [W-1:0]     byte_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [0:W];

  // load starts from the zero seed
  assign stage[0] = load_i ? '0 : crc_o;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][CRC_W-1] ^ byte_i[W-1-g];
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY[CRC_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                crc_o <= '0;
    else if (load_i || add_i)   crc_o <= stage[W];
  end
endmodule

// File: rtl/spd_guard.sv
module spd_guard
  import spd_guard_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic [ADDR_W-1:0] beat_addr_i,
  input  logic [7:0]        beat_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [2:0]        mem_type_o,
  output logic [1:0]        err_code_o
);
  localparam logic [ADDR_W-1:0] A_TYPE      = ADDR_W'(TYPE_POS);
  localparam logic [ADDR_W-1:0] A_SUM_LAST  = ADDR_W'(SUM_LAST_POS);
  localparam logic [ADDR_W-1:0] A_SUM       = ADDR_W'(SUM_POS);
  localparam logic [ADDR_W-1:0] A_CRC_SHORT = ADDR_W'(CRC_SHORT_POS);
  localparam logic [ADDR_W-1:0] A_CRC_LONG  = ADDR_W'(CRC_LONG_POS);
  localparam logic [ADDR_W-1:0] A_CRC_LO    = ADDR_W'(CRC_LO_POS);
  localparam logic [ADDR_W-1:0] A_CRC_HI    = ADDR_W'(CRC_HI_POS);

  state_e            state_q;
  method_e           method_q;
  mem_type_e         type_q, type_d;
  err_e              err_q;
  logic              pass_q, done_q, short_q;
  logic [7:0]        crc_lo_q;
  logic [7:0]        sum_w;
  logic [CRC_W-1:0]  crc_w;
  logic              start, run_beat, in_order, good;
  logic [ADDR_W-1:0] crc_last;

  assign start    = (state_q == S_IDLE) && beat_valid_i && (beat_addr_i == '0);
  assign run_beat = (state_q == S_RUN) && beat_valid_i;
  assign good     = run_beat && in_order;
  assign crc_last = short_q ? A_CRC_SHORT : A_CRC_LONG;
  assign type_d   = classify(beat_data_i);

  spd_seq_track #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .step_i     (run_beat),
    .addr_i     (beat_addr_i),
    .in_order_o (in_order)
  );

  spd_sum_acc #(.W(BYTE_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .add_i  (good && (beat_addr_i <= A_SUM_LAST)),
    .byte_i (beat_data_i),
    .sum_o  (sum_w)
  );

  spd_crc_acc #(.W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .add_i  (good && (beat_addr_i <= crc_last)),
    .byte_i (beat_data_i),
    .crc_o  (crc_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      method_q <= M_PEND;
      type_q   <= MT_NONE;
      err_q    <= E_NONE;
      pass_q   <= 1'b0;
      done_q   <= 1'b0;
      short_q  <= 1'b0;
      crc_lo_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q  <= S_RUN;
        method_q <= M_PEND;
        type_q   <= MT_NONE;
        err_q    <= E_NONE;
        pass_q   <= 1'b0;
        short_q  <= beat_data_i[7];
      end else if (run_beat && !in_order) begin
        state_q <= S_IDLE;
        done_q  <= 1'b1;
        err_q   <= E_SEQ;
      end else if (good) begin
        if (beat_addr_i == A_TYPE) begin
          type_q <= type_d;
          if (type_d == MT_NONE) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= E_UNSUP;
          end else begin
            method_q <= (type_d == MT_DDR3) ? M_CRC : M_SUM;
          end
        end else if (method_q == M_SUM && beat_addr_i == A_SUM) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          pass_q  <= (beat_data_i == sum_w);
          err_q   <= (beat_data_i == sum_w) ? E_NONE : E_MISMATCH;
        end else if (method_q == M_CRC && beat_addr_i == A_CRC_LO) begin
          crc_lo_q <= beat_data_i;
        end else if (method_q == M_CRC && beat_addr_i == A_CRC_HI) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          pass_q  <= ({beat_data_i, crc_lo_q} == crc_w);
          err_q   <= ({beat_data_i, crc_lo_q} == crc_w) ? E_NONE : E_MISMATCH;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign mem_type_o = type_q;
  assign err_code_o = err_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_pass_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> err_code_o == E_NONE);

  a_r2_pass_typed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> mem_type_o != MT_NONE);

  a_r7_unsup_at_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_code_o == E_UNSUP) |-> $past(beat_addr_i) == A_TYPE);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && beat_valid_i && beat_addr_i != '0) |=> !done_o);

  a_r8_seq_needs_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_code_o == E_SEQ) |-> $past(beat_valid_i));

endmodule

// File: tb/sim_spd_guard.sv
module sim_spd_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] data = '0;
  logic       done_w, pass_w;
  logic [2:0] type_w;
  logic [1:0] err_w;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0;
  int done_addr = -1;
  logic       cap_pass;
  logic [2:0] cap_type;
  logic [1:0] cap_err;
  logic [7:0] img [0:255];
  bit finished = 0;

  always #2 clk = ~clk;

  spd_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .beat_valid_i(valid), .beat_addr_i(addr),
    .beat_data_i(data), .done_o(done_w), .pass_o(pass_w),
    .mem_type_o(type_w), .err_code_o(err_w)
  );

  always @(negedge clk) if (done_w) begin
    done_cnt++;
    cap_pass = pass_w; cap_type = type_w; cap_err = err_w;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input int a, input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; addr = a[7:0]; data = d;
    @(negedge clk);
    valid = 1'b0;
    if (done_w) done_addr = a;
  endtask

  task automatic send(input int first, input int last, input int gap_max);
    for (int a = first; a <= last; a++) begin
      beat(a, img[a]);
      if (gap_max > 0) repeat ($urandom_range(gap_max)) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] ref_sum(input int last);
    logic [7:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + img[i];
    return s;
  endfunction

  function automatic logic [15:0] ref_crc(input int last);
    logic [15:0] c = '0;
    for (int i = 0; i <= last; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ img[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  // reference verdict: last beat address, pass, type, error
  task automatic expect_of(output int last, output bit p, output int t, output int e);
    case (img[2])
      8'd4, 8'd7, 8'd8: begin
        t = (img[2] == 8'd4) ? 1 : (img[2] == 8'd7) ? 2 : 3;
        last = 63;
        p = (ref_sum(62) == img[63]);
      end
      8'd11: begin
        t = 4; last = 127;
        p = (ref_crc(img[0][7] ? 116 : 125) == {img[127], img[126]});
      end
      default: begin t = 0; last = 2; p = 0; end
    endcase
    e = (t == 0) ? 2 : (p ? 0 : 1);
  endtask

  task automatic fill(input int t, input bit good, input bit short_cov);
    for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
    img[0][7] = short_cov;
    img[2] = t[7:0];
    if (t == 11) begin
      logic [15:0] c;
      c = ref_crc(short_cov ? 116 : 125);
      if (!good) c = c ^ 16'h0100;
      img[126] = c[7:0]; img[127] = c[15:8];
    end else begin
      img[63] = good ? ref_sum(62) : ref_sum(62) + 8'd1;
    end
  endtask

  task automatic run_full(input string req, input int gap_max);
    int last, t, e; bit p;
    expect_of(last, p, t, e);
    done_cnt = 0; done_addr = -1;
    send(0, last, gap_max);
    @(negedge clk);
    chk(done_w == 1'b0, {req, " done one cycle (R9)"}, done_w, 0);
    chk(done_cnt == 1 && done_addr == last, {req, " done after last beat"}, done_addr, last);
    chk(cap_pass == p, {req, " pass"}, cap_pass, p);
    chk(int'(cap_type) == t, {req, " type (R2)"}, cap_type, t);
    chk(int'(cap_err) == e, {req, " err"}, cap_err, e);
    chk(pass_w == p && int'(err_w) == e, {req, " result held (R9)"}, pass_w, p);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done_w == 0 && pass_w == 0, "R1 reset done/pass", {done_w, pass_w}, 0);
    chk(type_w == 0 && err_w == 0, "R1 reset type/err", {type_w, err_w}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(4, 1, 0);  run_full("R3 SDR good", 0);
    fill(7, 1, 1);  run_full("R3 DDR good", 2);
    fill(8, 0, 0);  run_full("R4 DDR2 bad sum", 1);
    fill(11, 1, 0); run_full("R5 DDR3 good long", 0);
    fill(11, 1, 1); run_full("R6 DDR3 good short", 0);
    fill(11, 0, 0); run_full("R5 DDR3 bad crc", 3);

    // R6: short coverage ignores bytes 117..125
    fill(11, 1, 1);
    for (int i = 117; i <= 125; i++) img[i] = img[i] ^ 8'h5a;
    run_full("R6 excluded bytes altered", 0);
    chk(cap_pass == 1'b1, "R6 excluded bytes no effect", cap_pass, 1);

    // R6: long coverage includes byte 120
    fill(11, 1, 0);
    img[120] = img[120] ^ 8'h01;
    run_full("R6 covered byte altered", 0);
    chk(cap_pass == 1'b0, "R6 covered byte counts", cap_pass, 0);

    // R7 unknown type
    fill(9, 1, 0);
    run_full("R7 unsupported", 0);
    chk(cap_err == 2'd2, "R7 unsupported code", cap_err, 2);

    // R10 idle beats ignored after a verdict
    fill(4, 1, 0); run_full("R10 setup", 0);
    done_cnt = 0;
    beat(5, 8'h33); beat(63, 8'h00);
    @(negedge clk);
    chk(done_cnt == 0, "R10 no done when idle", done_cnt, 0);
    chk(pass_w == 1 && type_w == 1 && err_w == 0, "R10 outputs held", {pass_w, type_w, err_w}, 9'b1_001_00);

    // R8 gap
    fill(4, 1, 0);
    done_cnt = 0; done_addr = -1;
    send(0, 9, 0); beat(11, 8'h00);
    @(negedge clk);
    chk(done_cnt == 1 && done_addr == 11, "R8 gap detected at beat", done_addr, 11);
    chk(cap_err == 2'd3 && cap_pass == 0, "R8 gap error code", cap_err, 3);

    // R8 repeated address
    fill(11, 1, 0);
    done_cnt = 0; done_addr = -1;
    send(0, 20, 0); beat(20, 8'h00);
    @(negedge clk);
    chk(done_cnt == 1 && done_addr == 20, "R8 repeat detected", done_addr, 20);
    chk(cap_err == 2'd3 && cap_pass == 0, "R8 repeat error code", cap_err, 3);

    // constrained random with idle gaps (R11)
    for (int k = 0; k < 40; k++) begin
      int sel, t;
      sel = $urandom_range(4);
      case (sel)
        0: t = 4; 1: t = 7; 2: t = 8; 3: t = 11;
        default: begin
          t = $urandom_range(255);
          if (t == 4 || t == 7 || t == 8 || t == 11) t = 0;
        end
      endcase
      fill(t, $urandom_range(1) == 1, $urandom_range(1) == 1);
      run_full("R11 random", 2);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule